// File: doc/BRIEF.md
# Radix-r Modulo r^n Ripple Adder

This block adds two residues modulo r^n. Each operand is held as n digits in base r, and each digit is coded in binary on its own small field. The block is a single combinational path: one digit cell per position, with a one-bit carry passed from each position to the next. Because the largest sum a cell can see is 2r−1, that carry needs only one bit whatever the radix.

The most significant position uses a cut-down cell that makes no carry. Dropping the carry out of the top digit is exactly the reduction modulo r^n, so the result wraps with no extra correction stage. A residue-arithmetic datapath uses this block for each channel whose modulus is a power of a small radix. The radix and the digit count are parameters.

Digit k of every bus sits in bits [k·DW+DW−1 : k·DW], where DW = ceil(log2 r), with a minimum of 1. Digit 0 is the least significant digit. An operand is legal when every digit is below r.

Top module: `rmod_ripple_add`

## Requirements
- R1: For legal operands, every digit field of `sum_o` holds a value below RADIX.
- R2: For legal operands A and B, the value of `sum_o` (the sum over k of digit k × RADIX^k) equals (A+B) mod RADIX^DIGITS.
- R3: Each lower position forms t = a+b+carry-in. When t ≥ RADIX, it outputs digit t−RADIX and a carry of 1. Otherwise it outputs digit t and a carry of 0. A carry raises the next digit by one.
- R4: The carry into digit 0 is zero. Adding zero to any legal A returns A unchanged, and adding zero to zero gives zero.
- R5: When both operands have every digit equal to RADIX−1, the result has digit 0 equal to RADIX−2 and every other digit equal to RADIX−1. In this case the carry ripples through every position.
- R6: The top position makes no carry. Any sum that reaches RADIX^DIGITS or more wraps, so (RADIX^DIGITS−1) + 1 gives 0.
- R7: The result does not depend on operand order: swapping A and B gives the same `sum_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | DIGITS*DW | First operand, binary-coded radix digits, digit 0 lowest |
| b_i | input | DIGITS*DW | Second operand, same coding |
| sum_o | output | DIGITS*DW | (a_i + b_i) mod RADIX^DIGITS, same coding |

## Verification
The bench runs every legal operand pair for the default radix and digit count. This full sweep catches any fault in how a digit is folded or in how the chain is wired, because every single-digit case and every carry pattern occurs. Separate directed cases isolate the remaining behaviour. Zero plus an operand shows that no stray carry enters digit 0. The all-(r−1) operands carry through every position. The value just below the modulus plus one shows that the top carry is dropped. Swapped operand pairs expose any asymmetry between the two inputs.

// File: rtl/rmod_pkg.sv
package rmod_pkg;

    typedef enum logic [0:0] {
        CELL_FULL = 1'b0,
        CELL_TOP  = 1'b1
    } cell_kind_e;

    function automatic int digit_width(input int radix);
        int w;
        w = $clog2(radix);
        if (w < 1) w = 1;
        return w;
    endfunction

    function automatic longint int_power(input int base, input int expo);
        longint acc;
        acc = 1;
        for (int k = 0; k < expo; k++) acc = acc * base;
        return acc;
    endfunction

endpackage

// File: rtl/rmod_digit_cell.sv
module rmod_digit_cell
    import rmod_pkg::*;
#(
    parameter int         RADIX = 5,
    parameter int         DW    = 3,
    parameter cell_kind_e KIND  = CELL_FULL
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] dig_o,
    output logic          cout_o
);
    localparam logic [DW:0] RAD = (DW+1)'(RADIX);

    logic [DW:0] total;
    logic [DW:0] less_rad;
    logic [DW:0] chosen;
    logic        over;
    logic        chosen_top_unused;

    always_comb begin
        total    = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
        over     = (total >= RAD);
        less_rad = total - RAD;
        chosen   = over ? less_rad : total;
    end

    assign dig_o             = chosen[DW-1:0];
    assign chosen_top_unused = chosen[DW];

    generate
        if (KIND == CELL_FULL) begin : g_carry
            assign cout_o = over;
        end else begin : g_nocarry
            assign cout_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rmod_ripple_add.sv
module rmod_ripple_add
    import rmod_pkg::*;
#(
    parameter int RADIX  = 5,
    parameter int DIGITS = 3,
    localparam int DW    = digit_width(RADIX),
    localparam int W     = DIGITS * DW
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [DIGITS-1:0] carry;
    logic              top_cout_unused;

    assign carry[0] = 1'b0;

    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_pos
            if (k < DIGITS - 1) begin : g_full
                rmod_digit_cell #(
                    .RADIX (RADIX),
                    .DW    (DW),
                    .KIND  (CELL_FULL)
                ) cell_i (
                    .a_i    (a_i[k*DW +: DW]),
                    .b_i    (b_i[k*DW +: DW]),
                    .cin_i  (carry[k]),
                    .dig_o  (sum_o[k*DW +: DW]),
                    .cout_o (carry[k+1])
                );
            end else begin : g_top
                rmod_digit_cell #(
                    .RADIX (RADIX),
                    .DW    (DW),
                    .KIND  (CELL_TOP)
                ) cell_i (
                    .a_i    (a_i[k*DW +: DW]),
                    .b_i    (b_i[k*DW +: DW]),
                    .cin_i  (carry[k]),
                    .dig_o  (sum_o[k*DW +: DW]),
                    .cout_o (top_cout_unused)
                );
            end
        end
    endgenerate

endmodule

// File: rtl/rmod_ripple_add_chk.sv
module rmod_ripple_add_chk
    import rmod_pkg::*;
#(
    parameter int RADIX  = 5,
    parameter int DIGITS = 3,
    parameter int DW     = 3
) (
    input logic [DIGITS*DW-1:0] a_i,
    input logic [DIGITS*DW-1:0] b_i,
    input logic [DIGITS*DW-1:0] sum_o,
    input logic [DIGITS-1:0]    carry
);
    localparam longint MODV = int_power(RADIX, DIGITS);

    function automatic bit legal(input logic [DIGITS*DW-1:0] v);
        bit ok;
        ok = !$isunknown(v);
        for (int k = 0; k < DIGITS; k++)
            if (int'(v[k*DW +: DW]) >= RADIX) ok = 0;
        return ok;
    endfunction

    function automatic longint value_of(input logic [DIGITS*DW-1:0] v);
        longint acc;
        acc = 0;
        for (int k = DIGITS - 1; k >= 0; k--) acc = acc * RADIX + longint'(v[k*DW +: DW]);
        return acc;
    endfunction

    logic ok_in;
    assign ok_in = legal(a_i) && legal(b_i) && !$isunknown(sum_o) && !$isunknown(carry);

    always_comb begin
        if (ok_in) begin
            for (int k = 0; k < DIGITS; k++)
                p_digit_range_r1: assert (int'(sum_o[k*DW +: DW]) < RADIX);
        end
    end

    always_comb begin
        if (ok_in)
            p_value_r2: assert (value_of(sum_o) == (value_of(a_i) + value_of(b_i)) % MODV);
    end

    always_comb begin
        if (ok_in) begin
            for (int k = 0; k < DIGITS - 1; k++)
                p_cell_balance_r3: assert (int'(a_i[k*DW +: DW]) + int'(b_i[k*DW +: DW]) + int'(carry[k])
                                           == int'(sum_o[k*DW +: DW]) + RADIX * int'(carry[k+1]));
        end
    end

    always_comb begin
        if (ok_in)
            p_low_digit_r4: assert (int'(sum_o[DW-1:0]) ==
                                    (int'(a_i[DW-1:0]) + int'(b_i[DW-1:0])) % RADIX);
    end

    always_comb begin
        if (ok_in)
            p_top_wrap_r6: assert (int'(sum_o[(DIGITS-1)*DW +: DW]) ==
                                   (int'(a_i[(DIGITS-1)*DW +: DW]) + int'(b_i[(DIGITS-1)*DW +: DW])
                                    + int'(carry[DIGITS-1])) % RADIX);
    end

endmodule

bind rmod_ripple_add rmod_ripple_add_chk #(
    .RADIX  (RADIX),
    .DIGITS (DIGITS),
    .DW     (DW)
) chk_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o),
    .carry (carry)
);

// File: tb/rmod_ripple_add_tb_top.sv
module rmod_ripple_add_tb_top;
    import rmod_pkg::*;

    localparam int RADIX  = 5;
    localparam int DIGITS = 3;
    localparam int DW     = digit_width(RADIX);
    localparam int W      = DIGITS * DW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [W-1:0] sum_o;

    rmod_ripple_add #(.RADIX(RADIX), .DIGITS(DIGITS)) dut_i (
        .a_i   (a_i),
        .b_i   (b_i),
        .sum_o (sum_o)
    );

    typedef struct {
        int    av;
        int    bv;
        int    ev;
        string req;
    } item_t;

    item_t queue_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    drv_done = 0;
    int    modv;

    function automatic logic [W-1:0] pack(input int v);
        logic [W-1:0] r;
        int rest;
        rest = v;
        r = '0;
        for (int k = 0; k < DIGITS; k++) begin
            r[k*DW +: DW] = DW'(rest % RADIX);
            rest = rest / RADIX;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input int av, input int bv, input int ev, input string req);
        item_t it;
        @(posedge clk);
        #1;
        a_i = pack(av);
        b_i = pack(bv);
        it.av = av; it.bv = bv; it.ev = ev; it.req = req;
        queue_q.push_back(it);
    endtask

    // monitor: compares at the falling edge, after inputs settled
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (queue_q.size() > 0) begin
                it = queue_q.pop_front();
                check(it.req, sum_o, pack(it.ev));
            end
        end
    end

    initial begin
        logic [W-1:0] expv;
        modv = int'(int_power(RADIX, DIGITS));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: zero plus zero right after reset
        check("R4 reset zero", sum_o, '0);

        drive(0, 0, 0, "R4");
        drive(modv / 2, 0, modv / 2, "R4");
        drive(0, modv - 1, modv - 1, "R4");
        // R3: single carry from digit 0 into digit 1
        drive(RADIX - 1, 1, RADIX, "R3");
        drive(RADIX - 2, 1, RADIX - 1, "R3");
        drive(2, RADIX - 1, RADIX + 1, "R3");
        // R5: all digits r-1
        drive(modv - 1, modv - 1, modv - 2, "R5");
        // R6: wrap to zero
        drive(modv - 1, 1, 0, "R6");
        drive(modv - RADIX, RADIX, 0, "R6");
        // R7: swapped operands
        drive(7, modv - 3, (7 + modv - 3) % modv, "R7");
        drive(modv - 3, 7, (7 + modv - 3) % modv, "R7");
        // R2 / R1: full sweep of legal pairs
        for (int x = 0; x < modv; x++)
            for (int y = 0; y < modv; y++)
                drive(x, y, (x + y) % modv, "R2");
        repeat (3) @(posedge clk);
        // R5 digit-level form
        @(negedge clk);
        a_i = pack(modv - 1);
        b_i = pack(modv - 1);
        #1;
        expv = '0;
        for (int k = 0; k < DIGITS; k++) expv[k*DW +: DW] = DW'(RADIX - 1);
        expv[DW-1:0] = DW'(RADIX - 2);
        check("R5 digits", sum_o, expv);
        // R1: every digit below radix
        for (int k = 0; k < DIGITS; k++) begin
            n_checks++;
            if (int'(sum_o[k*DW +: DW]) >= RADIX) begin
                n_fail++;
                $display("FAIL R1: actual %0d expected below %0d", sum_o[k*DW +: DW], RADIX);
            end
        end
        drv_done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!drv_done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!drv_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule